// File: doc/BRIEF.md
# NAND Flash Operation Sequencer

This block runs one complete NAND flash operation from a single write to its control word. An operation always starts with a command cycle. Up to five address cycles can follow, each one switched on by its own bit, so any mix of column and row bytes is possible. After that the sequencer can stall until the flash reports ready, and it can then move a counted number of bytes in or out. The host reaches the block through a small 32-bit word-indexed register port. Data passes through a byte-stream port, which stands in for a DMA engine. A sticky completion flag drives the interrupt line.

The flash side is an 8-bit IO bus (separate output, output-enable and input) with command-latch, address-latch, write-strobe, read-strobe and chip-select lines, plus a ready/busy input. Every strobe is low for `STROBE_LO` clock cycles and then high for `STROBE_HI` clock cycles. Chip-select stays low from the command cycle until the operation ends. The ready/busy input is assumed to be synchronous to `clk`.

Register word indices: 0 control, 1 configuration, 2 column address, 3 row address, 4 status.

Top module: `flash_op_sequencer`

## Requirements
- R1: After reset, chip-select, write strobe and read strobe are high, both latch lines are low, the IO output-enable is low, `irq` is low and control bit 31 reads 0.
- R2: While configuration bit 27 is 0, a start write is ignored: chip-select stays high, no strobe toggles and control bit 31 stays 0.
- R3: Writing control with bit 31 = 1 starts an operation whose first cycle is a command cycle. In that cycle command-latch is high, IO carries control bits 23:16, and the write strobe is low for exactly `STROBE_LO` cycles. Command-latch and address-latch are never high together.
- R4: Address enables sit in control bits 28:24, with bit 24 for byte 1 up to bit 28 for byte 5. Only enabled bytes are sent, with address-latch high, in ascending byte order after the command. Bytes 1 and 2 are bits 7:0 and 15:8 of the column register. Bytes 3, 4 and 5 are bits 7:0, 15:8 and 23:16 of the row register.
- R5: With control bit 15 set, no data strobe occurs while ready/busy is low between the address phase and the data phase.
- R6: With control bit 13 set (read), the sequencer issues as many read strobes as control bits 11:0 give. Each byte is sampled on the rising read strobe and presented on `rx_data` with a one-cycle `rx_valid` pulse.
- R7: With control bit 14 set (write), the sequencer sends as many bytes from `tx_data` as control bits 11:0 give. Each byte is taken in the cycle `tx_take` is high and is written with a write-strobe pulse while address-latch and command-latch are low.
- R8: If bits 13 and 14 are both set, or bits 11:0 are zero, the data phase is skipped: no data strobe, no `rx_valid` and no `tx_take`.
- R9: Control bit 31 reads 1 while an operation runs. A start write that arrives while busy is ignored.
- R10: If control bit 30 was set, status bit 0 and `irq` become 1 one cycle after the operation ends and stay 1 until a write with bit 0 set to status. Without bit 30 they stay 0.
- R11: Clearing configuration bit 27 during an operation returns the block to idle within one cycle. Chip-select goes high, busy reads 0 and no interrupt is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from `reg_addr`) |
| irq | output | 1 | Completion interrupt (sticky status bit 0) |
| fl_io_out | output | 8 | Flash IO bus, driven value |
| fl_io_oe | output | 1 | Flash IO bus output enable |
| fl_io_in | input | 8 | Flash IO bus, sampled value |
| fl_cmd_latch | output | 1 | Command latch enable |
| fl_addr_latch | output | 1 | Address latch enable |
| fl_wr_n | output | 1 | Write strobe, active low |
| fl_rd_n | output | 1 | Read strobe, active low |
| fl_sel_n | output | 1 | Chip select, active low |
| fl_ready | input | 1 | Flash ready (high) / busy (low) |
| rx_data | output | 8 | Byte read from flash |
| rx_valid | output | 1 | `rx_data` valid, one cycle per byte |
| tx_data | input | 8 | Next byte to write to flash |
| tx_take | output | 1 | `tx_data` consumed this cycle |

## Verification
A start write takes effect on the clock edge that accepts it. The busy bit is readable from the next cycle. Each strobe is low for `STROBE_LO` cycles and high for `STROBE_HI` cycles. `rx_valid` appears in the first cycle after a read strobe rises. `irq` rises one cycle after busy clears. An abort takes effect one cycle after the configuration write lands. The bench samples everything on the falling clock edge. It records each rising write strobe and each `rx_valid` as a tagged event and compares it in order against a queue filled before the start. It then polls busy and waits one or two extra falling edges before it looks at `irq` or chip-select.

// File: rtl/flash_seq_pkg.sv
// Shared types and constants for the NAND operation sequencer.
// Assumes a 32-bit register word and an 8-bit flash IO bus.
package flash_seq_pkg;
    localparam int REG_W     = 32;
    localparam int IO_W      = 8;
    localparam int NADDR     = 5;
    localparam int CNT_W     = 12;

    // register word indices
    localparam logic [2:0] RI_CTRL = 3'd0;
    localparam logic [2:0] RI_CFG  = 3'd1;
    localparam logic [2:0] RI_COL  = 3'd2;
    localparam logic [2:0] RI_ROW  = 3'd3;
    localparam logic [2:0] RI_STAT = 3'd4;

    // control word bit positions (decoded by the engine)
    localparam int CB_GO     = 31;
    localparam int CB_IE     = 30;
    localparam int CB_AMSK   = 24;
    localparam int CB_CMD    = 16;
    localparam int CB_WAIT   = 15;
    localparam int CB_WR     = 14;
    localparam int CB_RD     = 13;
    localparam int CFG_EN    = 27;

    typedef enum logic [2:0] {
        ST_IDLE, ST_CMD, ST_ADDR, ST_WAIT, ST_DATA
    } seq_state_t;
endpackage

// File: rtl/flash_seq_regs.sv
// Register bank: control, configuration, column/row address, status.
// Assumes single-cycle writes; reads are combinational from the index.
// The control word is frozen while an operation runs.
module flash_seq_regs
    import flash_seq_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    reg_we,
    input  logic [2:0]              reg_addr,
    input  logic [REG_W-1:0]        reg_wdata,
    output logic [REG_W-1:0]        reg_rdata,
    input  logic                    busy,
    input  logic                    op_done,
    output logic                    start,
    output logic [REG_W-1:0]        ctrl_q,
    output logic                    cfg_en,
    output logic [NADDR-1:0][IO_W-1:0] addr_bytes,
    output logic                    irq
);
    logic [REG_W-1:0] cfg_q;
    logic [2*IO_W-1:0] col_q;
    logic [3*IO_W-1:0] row_q;
    logic irq_q;

    assign cfg_en = cfg_q[CFG_EN];
    assign start  = reg_we && (reg_addr == RI_CTRL) && reg_wdata[CB_GO] && cfg_en && !busy;
    assign irq    = irq_q;

    // Address bytes in send order: column bytes first, then row bytes.
    for (genvar g = 0; g < NADDR; g++) begin : g_abyte
        if (g < 2) begin : g_col
            assign addr_bytes[g] = col_q[g*IO_W +: IO_W];
        end else begin : g_row
            assign addr_bytes[g] = row_q[(g-2)*IO_W +: IO_W];
        end
    end

    // Register writes; control is ignored while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            cfg_q  <= '0;
            col_q  <= '0;
            row_q  <= '0;
        end else if (reg_we) begin
            case (reg_addr)
                RI_CTRL: if (!busy) ctrl_q <= reg_wdata;
                RI_CFG:  cfg_q <= reg_wdata;
                RI_COL:  col_q <= reg_wdata[2*IO_W-1:0];
                RI_ROW:  row_q <= reg_wdata[3*IO_W-1:0];
                default: ;
            endcase
        end
    end

    // Sticky completion flag: set wins over write-one-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_q <= 1'b0;
        else if (op_done && ctrl_q[CB_IE])
            irq_q <= 1'b1;
        else if (reg_we && reg_addr == RI_STAT && reg_wdata[0])
            irq_q <= 1'b0;
    end

    // Read mux; control bit 31 reports busy.
    always_comb begin
        case (reg_addr)
            RI_CTRL: reg_rdata = {busy, ctrl_q[REG_W-2:0]};
            RI_CFG:  reg_rdata = cfg_q;
            RI_COL:  reg_rdata = {{(REG_W-2*IO_W){1'b0}}, col_q};
            RI_ROW:  reg_rdata = {{(REG_W-3*IO_W){1'b0}}, row_q};
            RI_STAT: reg_rdata = {{(REG_W-1){1'b0}}, irq_q};
            default: reg_rdata = '0;
        endcase
    end

    assert_irq_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_q && !(reg_we && reg_addr == RI_STAT && reg_wdata[0])) |=> irq_q);
    assert_irq_needs_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_q) |-> $past(op_done));
    assert_busy_freezes_ctrl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(ctrl_q));
endmodule

// File: rtl/flash_seq_engine.sv
// Operation engine: command, enabled address bytes, optional ready wait,
// optional counted data phase. Each strobe is low STROBE_LO cycles then
// high STROBE_HI cycles. Assumes the ready input is synchronous to clk.
module flash_seq_engine
    import flash_seq_pkg::*;
#(
    parameter int STROBE_LO = 2,
    parameter int STROBE_HI = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic                    cfg_en,
    input  logic [REG_W-1:0]        ctrl,
    input  logic [NADDR-1:0][IO_W-1:0] addr_bytes,
    output logic                    busy,
    output logic                    op_done,
    output logic [IO_W-1:0]         io_out,
    output logic                    io_oe,
    input  logic [IO_W-1:0]         io_in,
    output logic                    cmd_latch,
    output logic                    addr_latch,
    output logic                    wr_n,
    output logic                    rd_n,
    output logic                    sel_n,
    input  logic                    ready,
    output logic [IO_W-1:0]         rx_data,
    output logic                    rx_valid,
    input  logic [IO_W-1:0]         tx_data,
    output logic                    tx_take
);
    localparam int TMAX = (STROBE_LO > STROBE_HI) ? STROBE_LO : STROBE_HI;
    localparam int TW   = $clog2(TMAX + 1);

    seq_state_t      state;
    logic            ph_hi;
    logic [TW-1:0]   tcnt;
    logic [2:0]      aidx;
    logic [CNT_W-1:0] remain;
    logic [IO_W-1:0] wbyte;

    logic [NADDR-1:0] amask;
    logic [CNT_W-1:0] count;
    logic do_wr, do_rd, do_wait, data_go, strobing, lo_end, item_end;
    logic [3:0] na;
    seq_state_t after_addr;

    // Lowest enabled address byte at or above 'from'; {found, index}.
    function automatic logic [3:0] next_addr(input logic [NADDR-1:0] m, input logic [2:0] from);
        logic [3:0] r;
        r = 4'b0;
        for (int i = NADDR - 1; i >= 0; i--)
            if (m[i] && i >= int'(from)) r = {1'b1, 3'(i)};
        return r;
    endfunction

    assign amask    = ctrl[CB_AMSK +: NADDR];
    assign count    = ctrl[CNT_W-1:0];
    assign do_wr    = ctrl[CB_WR];
    assign do_rd    = ctrl[CB_RD];
    assign do_wait  = ctrl[CB_WAIT];
    assign data_go  = (do_rd ^ do_wr) && (count != '0);
    assign strobing = (state == ST_CMD) || (state == ST_ADDR) || (state == ST_DATA);
    assign lo_end   = strobing && !ph_hi && (tcnt == TW'(STROBE_LO - 1));
    assign item_end = strobing && ph_hi && (tcnt == TW'(STROBE_HI - 1));
    assign busy     = (state != ST_IDLE);

    // Pick the next address byte and the phase after the address bytes.
    always_comb begin
        na = next_addr(amask, (state == ST_CMD) ? 3'd0 : aidx + 3'd1);
        if (do_wait)      after_addr = ST_WAIT;
        else if (data_go) after_addr = ST_DATA;
        else              after_addr = ST_IDLE;
    end

    // Sequence state, strobe timer and byte counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE; ph_hi <= 1'b0; tcnt <= '0;
            aidx <= '0; remain <= '0; op_done <= 1'b0;
        end else begin
            op_done <= 1'b0;
            if (!cfg_en) begin
                state <= ST_IDLE; ph_hi <= 1'b0; tcnt <= '0;
            end else begin
                if (lo_end)        begin ph_hi <= 1'b1; tcnt <= '0; end
                else if (item_end) begin ph_hi <= 1'b0; tcnt <= '0; end
                else if (strobing) tcnt <= tcnt + TW'(1);
                else               begin ph_hi <= 1'b0; tcnt <= '0; end
                case (state)
                    ST_IDLE: if (start) state <= ST_CMD;
                    ST_CMD, ST_ADDR: if (item_end) begin
                        if (na[3]) begin
                            state <= ST_ADDR; aidx <= na[2:0];
                        end else begin
                            state <= after_addr;
                            remain <= count;
                            if (after_addr == ST_IDLE) op_done <= 1'b1;
                        end
                    end
                    ST_WAIT: if (ready) begin
                        remain <= count;
                        if (data_go) state <= ST_DATA;
                        else begin state <= ST_IDLE; op_done <= 1'b1; end
                    end
                    ST_DATA: if (item_end) begin
                        remain <= remain - CNT_W'(1);
                        if (remain == CNT_W'(1)) begin state <= ST_IDLE; op_done <= 1'b1; end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    // Write byte holding register and read byte capture on rising read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wbyte <= '0; rx_data <= '0; rx_valid <= 1'b0;
        end else begin
            if (tx_take) wbyte <= tx_data;
            rx_valid <= lo_end && (state == ST_DATA) && do_rd;
            if (lo_end && (state == ST_DATA) && do_rd) rx_data <= io_in;
        end
    end

    // Flash pin decode from the sequence state.
    always_comb begin
        sel_n      = (state == ST_IDLE);
        cmd_latch  = (state == ST_CMD);
        addr_latch = (state == ST_ADDR);
        io_oe      = (state == ST_CMD) || (state == ST_ADDR) || (state == ST_DATA && do_wr);
        wr_n       = !(strobing && !ph_hi && io_oe);
        rd_n       = !(strobing && !ph_hi && state == ST_DATA && do_rd);
        tx_take    = (state == ST_DATA) && do_wr && !ph_hi && (tcnt == '0);
        case (state)
            ST_CMD:  io_out = ctrl[CB_CMD +: IO_W];
            ST_ADDR: io_out = addr_bytes[aidx];
            ST_DATA: io_out = tx_take ? tx_data : wbyte;
            default: io_out = '0;
        endcase
    end

    assert_latch_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_latch && addr_latch));
    assert_strobe_needs_select_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_n || !rd_n) |-> !sel_n);
    assert_disable_idles_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> sel_n);
    assert_wait_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && !ready && cfg_en) |=> (state == ST_WAIT));
    assert_rx_after_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $rose(rd_n));
endmodule

// File: rtl/flash_op_sequencer.sv
// Top level: register bank plus operation engine.
// Assumes the flash ready/busy line is already synchronous to clk.
module flash_op_sequencer
    import flash_seq_pkg::*;
#(
    parameter int STROBE_LO = 2,
    parameter int STROBE_HI = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq,
    output logic [7:0]        fl_io_out,
    output logic              fl_io_oe,
    input  logic [7:0]        fl_io_in,
    output logic              fl_cmd_latch,
    output logic              fl_addr_latch,
    output logic              fl_wr_n,
    output logic              fl_rd_n,
    output logic              fl_sel_n,
    input  logic              fl_ready,
    output logic [7:0]        rx_data,
    output logic              rx_valid,
    input  logic [7:0]        tx_data,
    output logic              tx_take
);
    logic busy, op_done, start, cfg_en;
    logic [REG_W-1:0] ctrl_q;
    logic [NADDR-1:0][IO_W-1:0] addr_bytes;

    flash_seq_regs u_regs (
        .clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .reg_rdata,
        .busy, .op_done, .start, .ctrl_q, .cfg_en, .addr_bytes, .irq
    );

    flash_seq_engine #(.STROBE_LO(STROBE_LO), .STROBE_HI(STROBE_HI)) u_engine (
        .clk, .rst_n, .start, .cfg_en, .ctrl(ctrl_q), .addr_bytes,
        .busy, .op_done,
        .io_out(fl_io_out), .io_oe(fl_io_oe), .io_in(fl_io_in),
        .cmd_latch(fl_cmd_latch), .addr_latch(fl_addr_latch),
        .wr_n(fl_wr_n), .rd_n(fl_rd_n), .sel_n(fl_sel_n), .ready(fl_ready),
        .rx_data, .rx_valid, .tx_data, .tx_take
    );
endmodule

// File: tb/flash_op_sequencer_tb.sv
// Scoreboard bench: tests push expected flash events into a queue; a
// falling-edge monitor with a behavioural flash model pops and compares.
module flash_op_sequencer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int STROBE_LO  = 2;
    localparam int STROBE_HI  = 2;
    localparam int WD_LIMIT   = 100000;

    logic clk = 1'b0;
    logic rst_n;
    logic reg_we;
    logic [2:0] reg_addr;
    logic [31:0] reg_wdata, reg_rdata;
    logic irq;
    logic [7:0] fl_io_out, fl_io_in;
    logic fl_io_oe, fl_cmd_latch, fl_addr_latch, fl_wr_n, fl_rd_n, fl_sel_n;
    logic fl_ready;
    logic [7:0] rx_data, tx_data;
    logic rx_valid, tx_take;

    int errors = 0, checks = 0, cyc = 0;
    bit finished = 0;
    logic [9:0] expq[$];
    logic [7:0] tx_src [0:7];
    int tx_idx = 0;

    // flash model state
    logic [7:0] last_cmd = 8'hFF, pcol = 8'h00, prow = 8'h00;
    int kread = 0, acnt = 0, busy_cnt = 0, we_low = 0;
    logic prev_wr = 1'b1, prev_rd = 1'b1;
    bit rb_viol = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_op_sequencer #(.STROBE_LO(STROBE_LO), .STROBE_HI(STROBE_HI)) u_dut (
        .clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .reg_rdata, .irq,
        .fl_io_out, .fl_io_oe, .fl_io_in, .fl_cmd_latch, .fl_addr_latch,
        .fl_wr_n, .fl_rd_n, .fl_sel_n, .fl_ready,
        .rx_data, .rx_valid, .tx_data, .tx_take
    );

    assign tx_data = tx_src[tx_idx[2:0]];
    always @(posedge clk) if (tx_take) tx_idx <= tx_idx + 1;

    function automatic logic [7:0] id_byte(input int k);
        case (k)
            0: return 8'hEC;
            1: return 8'hD3;
            2: return 8'h51;
            3: return 8'h95;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [31:0] mk_ctrl(input bit go, input bit ie, input logic [4:0] am,
        input logic [7:0] cmd, input bit wt, input bit wr, input bit rd, input logic [11:0] cnt);
        return {go, ie, 1'b0, am, cmd, wt, wr, rd, 1'b0, cnt};
    endfunction

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic observe(input logic [1:0] k, input logic [7:0] v, input string req);
        logic [9:0] e;
        checks++;
        if (expq.size() == 0) begin
            errors++;
            $display("FAIL %s: unexpected event actual=%0h expected=none", req, {k, v});
        end else begin
            e = expq.pop_front();
            if (e != {k, v}) begin
                errors++;
                $display("FAIL %s: event actual=%0h expected=%0h", req, {k, v}, e);
            end
        end
    endtask

    // Monitor and flash model, all on the falling edge.
    always @(negedge clk) begin
        cyc++;
        if (busy_cnt > 0) busy_cnt--;
        fl_ready = (busy_cnt == 0);
        if (!fl_rd_n && !fl_ready) rb_viol = 1;
        if (!fl_wr_n) we_low++;
        if (!prev_wr && fl_wr_n) begin
            check(we_low == STROBE_LO, "R3", "write strobe low cycles", we_low, STROBE_LO);
            we_low = 0;
            if (fl_cmd_latch) begin
                observe(2'd0, fl_io_out, "R3");
                last_cmd = fl_io_out; kread = 0; acnt = 0;
                if (fl_io_out == 8'h30) busy_cnt = 12;
                if (fl_io_out == 8'hD0) busy_cnt = 300;
                fl_ready = (busy_cnt == 0);
            end else if (fl_addr_latch) begin
                observe(2'd1, fl_io_out, "R4");
                if (last_cmd == 8'h00) begin
                    if (acnt == 0) pcol = fl_io_out;
                    if (acnt == 2) prow = fl_io_out;
                end
                acnt++;
            end else begin
                observe(2'd2, fl_io_out, "R7");
            end
        end
        if (prev_rd && !fl_rd_n) begin
            fl_io_in = (last_cmd == 8'h90) ? id_byte(kread) : ((pcol + 8'(kread)) ^ prow);
            kread++;
        end
        if (rx_valid) observe(2'd3, rx_data, "R6");
        prev_wr = fl_wr_n;
        prev_rd = fl_rd_n;
        if (cyc == WD_LIMIT && !finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk); reg_addr = a; #1; d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] d;
        for (int i = 0; i < 5000; i++) begin
            reg_read(3'd0, d);
            if (!d[31]) break;
        end
    endtask

    task automatic op_end(input string req);
        repeat (2) @(negedge clk);
        check(expq.size() == 0, req, "pending expected events", expq.size(), 0);
    endtask

    initial begin
        logic [31:0] d;
        bit quiet;
        rst_n = 1'b0; reg_we = 1'b0; reg_addr = 3'd0; reg_wdata = '0;
        fl_io_in = 8'h00; fl_ready = 1'b1;
        tx_src[0] = 8'hA5; tx_src[1] = 8'h5A; tx_src[2] = 8'hC3; tx_src[3] = 8'h3C;
        tx_src[4] = 8'h00; tx_src[5] = 8'h00; tx_src[6] = 8'h00; tx_src[7] = 8'h00;
        repeat (3) @(negedge clk);
        // R1: pins after reset
        check(fl_sel_n && fl_wr_n && fl_rd_n, "R1", "select/strobes high",
              {fl_sel_n, fl_wr_n, fl_rd_n}, 3'b111);
        check(!fl_cmd_latch && !fl_addr_latch && !fl_io_oe && !irq, "R1", "latches/oe/irq low",
              {fl_cmd_latch, fl_addr_latch, fl_io_oe, irq}, 0);
        rst_n = 1'b1;
        reg_read(3'd0, d);
        check(d[31] == 1'b0, "R1", "busy after reset", d[31], 0);

        // R2: start ignored while disabled
        reg_write(3'd0, mk_ctrl(1, 0, 5'b00001, 8'h90, 0, 0, 1, 4));
        quiet = 1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (!fl_sel_n || !fl_wr_n || !fl_rd_n) quiet = 0;
        end
        check(quiet, "R2", "flash pins quiet while disabled", quiet, 1);
        reg_read(3'd0, d);
        check(d[31] == 1'b0, "R2", "busy while disabled", d[31], 0);

        reg_write(3'd1, 32'h0800_0000);

        // Chip-ID: cmd 0x90, one address byte, 4-byte read, interrupt on
        reg_write(3'd2, 32'h0000_0000);
        expq.push_back({2'd0, 8'h90});
        expq.push_back({2'd1, 8'h00});
        for (int k = 0; k < 4; k++) expq.push_back({2'd3, id_byte(k)});
        reg_write(3'd0, mk_ctrl(1, 1, 5'b00001, 8'h90, 0, 0, 1, 4));
        reg_read(3'd0, d);
        check(d[31] == 1'b1, "R9", "busy during operation", d[31], 1);
        reg_write(3'd0, mk_ctrl(1, 0, 5'b11111, 8'h55, 0, 1, 0, 9)); // R9: ignored
        wait_idle();
        op_end("R9");
        check(irq == 1'b1, "R10", "irq after completion", irq, 1);
        reg_read(3'd4, d);
        check(d[0] == 1'b1, "R10", "status bit 0", d[0], 1);
        repeat (5) @(negedge clk);
        check(irq == 1'b1, "R10", "irq sticky", irq, 1);
        reg_write(3'd4, 32'h1);
        check(irq == 1'b0, "R10", "irq after write-one-clear", irq, 0);

        // Page read, part 1: cmd 0x00 with all five address bytes
        reg_write(3'd2, 32'h0000_0234);
        reg_write(3'd3, 32'h0001_5678);
        expq.push_back({2'd0, 8'h00});
        expq.push_back({2'd1, 8'h34}); expq.push_back({2'd1, 8'h02});
        expq.push_back({2'd1, 8'h78}); expq.push_back({2'd1, 8'h56});
        expq.push_back({2'd1, 8'h01});
        reg_write(3'd0, mk_ctrl(1, 0, 5'b11111, 8'h00, 0, 0, 0, 0));
        wait_idle();
        op_end("R4");

        // Page read, part 2: cmd 0x30, ready wait, 6-byte read
        rb_viol = 0;
        expq.push_back({2'd0, 8'h30});
        for (int k = 0; k < 6; k++) expq.push_back({2'd3, (8'h34 + 8'(k)) ^ 8'h78});
        reg_write(3'd0, mk_ctrl(1, 0, 5'b00000, 8'h30, 1, 0, 1, 6));
        wait_idle();
        op_end("R6");
        check(rb_viol == 0, "R5", "read strobe while flash busy", rb_viol, 0);
        check(irq == 1'b0, "R10", "no irq without enable", irq, 0);

        // R4: sparse enables, bytes 2 and 4 only
        expq.push_back({2'd0, 8'h60});
        expq.push_back({2'd1, 8'h02});
        expq.push_back({2'd1, 8'h56});
        reg_write(3'd0, mk_ctrl(1, 0, 5'b01010, 8'h60, 0, 0, 0, 0));
        wait_idle();
        op_end("R4");

        // R7: three-byte write
        expq.push_back({2'd0, 8'h80});
        expq.push_back({2'd1, 8'h34});
        expq.push_back({2'd2, 8'hA5}); expq.push_back({2'd2, 8'h5A});
        expq.push_back({2'd2, 8'hC3});
        reg_write(3'd0, mk_ctrl(1, 0, 5'b00001, 8'h80, 0, 1, 0, 3));
        wait_idle();
        op_end("R7");
        check(tx_idx == 3, "R7", "bytes taken from stream", tx_idx, 3);

        // R8: both directions set, then zero count
        expq.push_back({2'd0, 8'h11});
        reg_write(3'd0, mk_ctrl(1, 0, 5'b00000, 8'h11, 0, 1, 1, 5));
        wait_idle();
        op_end("R8");
        check(tx_idx == 3, "R8", "no bytes taken when both flags set", tx_idx, 3);
        expq.push_back({2'd0, 8'h12});
        reg_write(3'd0, mk_ctrl(1, 0, 5'b00000, 8'h12, 0, 0, 1, 0));
        wait_idle();
        op_end("R8");

        // R11: abort a waiting operation by clearing the enable
        expq.push_back({2'd0, 8'hD0});
        reg_write(3'd0, mk_ctrl(1, 1, 5'b00000, 8'hD0, 1, 0, 1, 2));
        repeat (30) @(negedge clk);
        reg_write(3'd1, 32'h0);
        @(negedge clk);
        check(fl_sel_n == 1'b1, "R11", "select after abort", fl_sel_n, 1);
        reg_read(3'd0, d);
        check(d[31] == 1'b0, "R11", "busy after abort", d[31], 0);
        op_end("R11");
        check(irq == 1'b0, "R11", "no irq on abort", irq, 0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule